// File: doc/BRIEF.md
# Workload-Aware Scheduler and Power Gate Controller

This block sits between the region-finding front stage and a pool of sixteen worker processors. Once per frame it takes the number of region tiles the front stage produced and ranks that number against a set of programmable, ascending thresholds to get a workload level. The level decides how many workers take part in the frame and how many of the four worker power domains must be on. The domain enables go straight out to the external regulators.

After a frame is accepted, the block counts a programmable number of settling cycles. It then hands out one tile per cycle, round-robin, to the active workers only. A frame request that arrives while a frame is in progress is dropped, so power is switched at most once per frame.

Each worker also has a clock enable. A worker turns its own clock off by writing to one of two addresses. A write to the end address gates the clock until the worker is given its next tile. A write to the wait address stores a mask of pending conditions, and the clock stays gated until every one of those conditions has been cleared.

Top module: `frame_power_sched`

## Requirements
- R1: The workload level is the number of thresholds that the tile count reaches. Threshold i sits in bits [i*CNT_W +: CNT_W] of the threshold bus, the thresholds are ascending, and a count equal to a threshold counts as reaching it.
- R2: The number of active workers is (level+1)*NUM_WORKERS/NUM_LEVELS, so 4, 8, 12 or 16 by default. Lowering the thresholds gives the same tile count more active workers.
- R3: Domain d powers workers d*4 to d*4+3. Bit d of the domain enable is high exactly when at least one worker in domain d is active. The enables take their new value in the cycle after a frame is accepted and hold it until the next frame is accepted.
- R4: The first tile is issued exactly max(S,1) cycles after the domain enables update, where S is the settle setting. No tile ever goes to a worker whose domain is off.
- R5: The busy output is high from acceptance until the last tile of the frame. A frame request while busy is ignored: the level, the enables and the tile stream are unchanged.
- R6: Tiles 0 to count-1 are issued one per cycle in order. Tile i goes to worker i mod the active-worker count. A frame with zero tiles issues nothing and returns to idle after the settle interval.
- R7: A write to the end address (address bit 0) clears that worker's clock enable from the next cycle until a tile is issued to it.
- R8: A write to the wait address (address bit 1) stores a mask of pending conditions and gates the worker's clock while any bit is pending. A wait-clear pulse removes its bits, and the clock returns once none are left. A clear bit in the same cycle as the write already counts as resolved.
- R9: When an end write and a tile issue to the same worker fall in the same cycle, the tile wins and the worker's clock stays enabled.
- R10: A worker's clock enable is high only while its domain is enabled.
- R11: After reset: not busy, no tile issued, level 0, all domain enables low, all clock enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame request pulse that carries the tile count |
| tile_count | input | CNT_W | Number of region tiles in the frame |
| thr_flat | input | (NUM_LEVELS-1)*CNT_W | Packed ascending thresholds |
| settle_cycles | input | SETTLE_W | Regulator settling interval in cycles |
| busy | output | 1 | A frame is being settled or dispatched |
| level | output | LVL_W | Workload level of the current frame |
| n_active | output | ACT_W | Active worker count of the current frame |
| dom_en | output | NUM_DOMAINS | Regulator enable for each domain |
| disp_valid | output | 1 | A tile is issued this cycle |
| disp_worker | output | WID_W | Worker that receives the tile |
| disp_tile | output | CNT_W | Index of the issued tile |
| cg_wr_en | input | 1 | Worker gate-control write strobe |
| cg_wr_addr | input | 1 | 0 = end address, 1 = wait address |
| cg_wr_id | input | WID_W | Worker that writes |
| cg_wr_data | input | WAIT_W | Wait-condition mask |
| wait_clear | input | WAIT_W | Pulses that resolve wait conditions |
| clk_en | output | NUM_WORKERS | Clock enable for each worker |

## Verification
Two things can hit one worker in the same cycle: tile dispatch and that worker's own end write. To provoke this, the bench watches the tile stream during a frame and drives an end write from worker 3 half a cycle before that worker's tile is registered, so both arrive at the same edge. The result is judged by sampling the worker's clock enable one cycle later: it must still be high. A second overlap covers a wait write and a clear of the same condition in one cycle, which must leave the clock running.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SETTLE   = 2'd1,
        ST_DISPATCH = 2'd2
    } sched_state_e;

    localparam logic CG_ADDR_END  = 1'b0;
    localparam logic CG_ADDR_WAIT = 1'b1;
endpackage

// File: rtl/wl_classify.sv
module wl_classify #(
    parameter int NUM_WORKERS = 16,
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_LEVELS  = 4,
    parameter int CNT_W       = 10,
    parameter int LVL_W       = 2,
    parameter int ACT_W       = 5
) (
    input  logic [CNT_W-1:0]                tile_count,
    input  logic [(NUM_LEVELS-1)*CNT_W-1:0] thr_flat,
    output logic [LVL_W-1:0]                level,
    output logic [ACT_W-1:0]                n_active,
    output logic [NUM_DOMAINS-1:0]          dom_mask
);
    localparam int WPD = NUM_WORKERS / NUM_DOMAINS;

    logic [NUM_LEVELS-2:0] hit;
    int                    act_i;

    // one comparator per threshold
    for (genvar i = 0; i < NUM_LEVELS - 1; i++) begin : g_thr
        assign hit[i] = tile_count >= thr_flat[i*CNT_W +: CNT_W];
    end

    always_comb begin
        int lv;
        lv = 0;
        for (int i = 0; i < NUM_LEVELS - 1; i++) begin
            if (hit[i]) lv++;
        end
        act_i    = ((lv + 1) * NUM_WORKERS) / NUM_LEVELS;
        level    = LVL_W'(lv);
        n_active = ACT_W'(act_i);
    end

    // a domain is needed when its lowest worker is active
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        assign dom_mask[d] = (d * WPD) < act_i;
    end
endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
    import sched_pkg::*;
#(
    parameter int NUM_DOMAINS = 4,
    parameter int CNT_W       = 10,
    parameter int SETTLE_W    = 16,
    parameter int LVL_W       = 2,
    parameter int ACT_W       = 5,
    parameter int WID_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic [CNT_W-1:0]       tile_count,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    input  logic [LVL_W-1:0]       cls_level,
    input  logic [ACT_W-1:0]       cls_active,
    input  logic [NUM_DOMAINS-1:0] cls_dom,
    output logic                   busy,
    output logic [LVL_W-1:0]       level,
    output logic [ACT_W-1:0]       n_active,
    output logic [NUM_DOMAINS-1:0] dom_en,
    output logic                   disp_valid,
    output logic [WID_W-1:0]       disp_worker,
    output logic [CNT_W-1:0]       disp_tile
);
    typedef struct packed {
        sched_state_e           st;
        logic [SETTLE_W-1:0]    cnt;
        logic [SETTLE_W-1:0]    settle;
        logic [CNT_W-1:0]       total;
        logic [CNT_W-1:0]       idx;
        logic [WID_W-1:0]       rr;
        logic [LVL_W-1:0]       level;
        logic [ACT_W-1:0]       active;
        logic [NUM_DOMAINS-1:0] dom;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    // the one power decision of the frame
                    fsm_d.st     = ST_SETTLE;
                    fsm_d.cnt    = '0;
                    fsm_d.settle = settle_cycles;
                    fsm_d.total  = tile_count;
                    fsm_d.idx    = '0;
                    fsm_d.rr     = '0;
                    fsm_d.level  = cls_level;
                    fsm_d.active = cls_active;
                    fsm_d.dom    = cls_dom;
                end
            end
            ST_SETTLE: begin
                if (fsm_q.cnt + SETTLE_W'(1) >= fsm_q.settle) begin
                    fsm_d.st = (fsm_q.total == '0) ? ST_IDLE : ST_DISPATCH;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + SETTLE_W'(1);
                end
            end
            ST_DISPATCH: begin
                if (fsm_q.idx == fsm_q.total - CNT_W'(1)) begin
                    fsm_d.st = ST_IDLE;
                end else begin
                    fsm_d.idx = fsm_q.idx + CNT_W'(1);
                end
                if (ACT_W'(fsm_q.rr) + ACT_W'(1) >= fsm_q.active) begin
                    fsm_d.rr = '0;
                end else begin
                    fsm_d.rr = fsm_q.rr + WID_W'(1);
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign busy        = fsm_q.st != ST_IDLE;
    assign level       = fsm_q.level;
    assign n_active    = fsm_q.active;
    assign dom_en      = fsm_q.dom;
    assign disp_valid  = fsm_q.st == ST_DISPATCH;
    assign disp_worker = fsm_q.rr;
    assign disp_tile   = fsm_q.idx;
endmodule

// File: rtl/cg_slot.sv
module cg_slot #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_req,
    input  logic              wait_req,
    input  logic [WAIT_W-1:0] wait_data,
    input  logic [WAIT_W-1:0] wait_clear,
    input  logic              dispatched,
    input  logic              dom_on,
    output logic              clk_en
);
    typedef struct packed {
        logic              ended;
        logic [WAIT_W-1:0] pend;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        // a clear in the write cycle already counts as resolved
        if (wait_req) slot_d.pend = wait_data & ~wait_clear;
        else          slot_d.pend = slot_q.pend & ~wait_clear;
        // new work beats a same-cycle end request
        if (dispatched)   slot_d.ended = 1'b0;
        else if (end_req) slot_d.ended = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign clk_en = dom_on & ~slot_q.ended & ~|slot_q.pend;
endmodule

// File: rtl/frame_power_sched.sv
module frame_power_sched
    import sched_pkg::*;
#(
    parameter int NUM_WORKERS = 16,
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_LEVELS  = 4,
    parameter int CNT_W       = 10,
    parameter int SETTLE_W    = 16,
    parameter int WAIT_W      = 4,
    parameter int WID_W       = $clog2(NUM_WORKERS),
    parameter int LVL_W       = (NUM_LEVELS > 2) ? $clog2(NUM_LEVELS) : 1,
    parameter int ACT_W       = $clog2(NUM_WORKERS + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic [CNT_W-1:0]                tile_count,
    input  logic [(NUM_LEVELS-1)*CNT_W-1:0] thr_flat,
    input  logic [SETTLE_W-1:0]             settle_cycles,
    output logic                            busy,
    output logic [LVL_W-1:0]                level,
    output logic [ACT_W-1:0]                n_active,
    output logic [NUM_DOMAINS-1:0]          dom_en,
    output logic                            disp_valid,
    output logic [WID_W-1:0]                disp_worker,
    output logic [CNT_W-1:0]                disp_tile,
    input  logic                            cg_wr_en,
    input  logic                            cg_wr_addr,
    input  logic [WID_W-1:0]                cg_wr_id,
    input  logic [WAIT_W-1:0]               cg_wr_data,
    input  logic [WAIT_W-1:0]               wait_clear,
    output logic [NUM_WORKERS-1:0]          clk_en
);
    localparam int WPD = NUM_WORKERS / NUM_DOMAINS;

    logic [LVL_W-1:0]       cls_level;
    logic [ACT_W-1:0]       cls_active;
    logic [NUM_DOMAINS-1:0] cls_dom;

    wl_classify #(
        .NUM_WORKERS(NUM_WORKERS), .NUM_DOMAINS(NUM_DOMAINS),
        .NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W),
        .LVL_W(LVL_W), .ACT_W(ACT_W)
    ) u_classify (
        .tile_count(tile_count),
        .thr_flat  (thr_flat),
        .level     (cls_level),
        .n_active  (cls_active),
        .dom_mask  (cls_dom)
    );

    sched_fsm #(
        .NUM_DOMAINS(NUM_DOMAINS), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W),
        .LVL_W(LVL_W), .ACT_W(ACT_W), .WID_W(WID_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .tile_count   (tile_count),
        .settle_cycles(settle_cycles),
        .cls_level    (cls_level),
        .cls_active   (cls_active),
        .cls_dom      (cls_dom),
        .busy         (busy),
        .level        (level),
        .n_active     (n_active),
        .dom_en       (dom_en),
        .disp_valid   (disp_valid),
        .disp_worker  (disp_worker),
        .disp_tile    (disp_tile)
    );

    for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_worker
        logic hit_id;
        assign hit_id = cg_wr_en && (cg_wr_id == WID_W'(w));

        cg_slot #(.WAIT_W(WAIT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .end_req   (hit_id && (cg_wr_addr == CG_ADDR_END)),
            .wait_req  (hit_id && (cg_wr_addr == CG_ADDR_WAIT)),
            .wait_data (cg_wr_data),
            .wait_clear(wait_clear),
            .dispatched(disp_valid && (disp_worker == WID_W'(w))),
            .dom_on    (dom_en[w / WPD]),
            .clk_en    (clk_en[w])
        );
    end
endmodule

// File: rtl/frame_power_sched_chk.sv
module frame_power_sched_chk #(
    parameter int NUM_WORKERS = 16,
    parameter int NUM_DOMAINS = 4,
    parameter int SETTLE_W    = 16,
    parameter int WAIT_W      = 4,
    parameter int WID_W       = 4,
    parameter int ACT_W       = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SETTLE_W-1:0]    settle_cycles,
    input logic                   busy,
    input logic [ACT_W-1:0]       n_active,
    input logic [NUM_DOMAINS-1:0] dom_en,
    input logic                   disp_valid,
    input logic [WID_W-1:0]       disp_worker,
    input logic                   cg_wr_en,
    input logic                   cg_wr_addr,
    input logic [WID_W-1:0]       cg_wr_id,
    input logic [WAIT_W-1:0]      cg_wr_data,
    input logic [WAIT_W-1:0]      wait_clear,
    input logic [NUM_WORKERS-1:0] clk_en
);
    localparam int WPD = NUM_WORKERS / NUM_DOMAINS;

    logic busy_prev;
    int   since_cnt;

    // cycles elapsed since the frame was accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_prev <= 1'b0;
            since_cnt <= 0;
        end else begin
            busy_prev <= busy;
            if (busy && !busy_prev) since_cnt <= 1;
            else if (busy)          since_cnt <= since_cnt + 1;
        end
    end

    p_dom_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(dom_en));

    p_disp_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> dom_en[disp_worker / WPD]);

    p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> since_cnt >= int'(settle_cycles));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !disp_valid);

    p_rr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ACT_W'(disp_worker) < n_active);

    p_end_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cg_wr_en && !cg_wr_addr && !(disp_valid && disp_worker == cg_wr_id)
        |=> !clk_en[$past(cg_wr_id)]);

    p_wait_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cg_wr_en && cg_wr_addr && ((cg_wr_data & ~wait_clear) != '0)
        |=> !clk_en[$past(cg_wr_id)]);

    for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_pw
        p_clk_needs_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[w] |-> dom_en[w / WPD]);
    end
endmodule

bind frame_power_sched frame_power_sched_chk #(
    .NUM_WORKERS(NUM_WORKERS), .NUM_DOMAINS(NUM_DOMAINS), .SETTLE_W(SETTLE_W),
    .WAIT_W(WAIT_W), .WID_W(WID_W), .ACT_W(ACT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .settle_cycles(settle_cycles),
    .busy         (busy),
    .n_active     (n_active),
    .dom_en       (dom_en),
    .disp_valid   (disp_valid),
    .disp_worker  (disp_worker),
    .cg_wr_en     (cg_wr_en),
    .cg_wr_addr   (cg_wr_addr),
    .cg_wr_id     (cg_wr_id),
    .cg_wr_data   (cg_wr_data),
    .wait_clear   (wait_clear),
    .clk_en       (clk_en)
);

// File: tb/frame_power_sched_bench.sv
module frame_power_sched_bench;
    localparam int NW = 16;
    localparam int ND = 4;
    localparam int CW = 10;
    localparam int SW = 16;
    localparam int WW = 4;
    localparam int IW = 4;
    localparam int LW = 2;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_start;
    logic [CW-1:0] tile_count;
    logic [3*CW-1:0] thr_flat;
    logic [SW-1:0] settle_cycles;
    logic          busy;
    logic [LW-1:0] level;
    logic [AW-1:0] n_active;
    logic [ND-1:0] dom_en;
    logic          disp_valid;
    logic [IW-1:0] disp_worker;
    logic [CW-1:0] disp_tile;
    logic          cg_wr_en;
    logic          cg_wr_addr;
    logic [IW-1:0] cg_wr_id;
    logic [WW-1:0] cg_wr_data;
    logic [WW-1:0] wait_clear;
    logic [NW-1:0] clk_en;

    always #4 clk = ~clk;

    frame_power_sched u_frame_power_sched (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .tile_count(tile_count), .thr_flat(thr_flat),
        .settle_cycles(settle_cycles), .busy(busy), .level(level),
        .n_active(n_active), .dom_en(dom_en), .disp_valid(disp_valid),
        .disp_worker(disp_worker), .disp_tile(disp_tile),
        .cg_wr_en(cg_wr_en), .cg_wr_addr(cg_wr_addr), .cg_wr_id(cg_wr_id),
        .cg_wr_data(cg_wr_data), .wait_clear(wait_clear), .clk_en(clk_en)
    );

    typedef struct {
        int w;
        int t;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares each issued tile against the scoreboard (R6)
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && disp_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R6 unexpected tile", int'(disp_tile), -1);
            end else begin
                e = sbq.pop_front();
                check(int'(disp_worker) == e.w && int'(disp_tile) == e.t, "R6 tile order",
                      int'(disp_worker) * 1000 + int'(disp_tile), e.w * 1000 + e.t);
            end
        end
    end

    task automatic set_thr(input int a, input int b, input int c);
        thr_flat = {CW'(c), CW'(b), CW'(a)};
    endtask

    task automatic run_frame(input int cnt, input int settle, input int exp_lvl);
        int exp_act;
        int exp_dom;
        int cyc;
        int gap;
        exp_act = (exp_lvl + 1) * 4;
        exp_dom = (1 << (exp_lvl + 1)) - 1;
        gap     = (settle < 1) ? 1 : settle;
        for (int i = 0; i < cnt; i++) sbq.push_back('{i % exp_act, i});
        @(negedge clk);
        tile_count    = CW'(cnt);
        settle_cycles = SW'(settle);
        frame_start   = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        cyc = 1;
        check(int'(level) == exp_lvl, "R1 level", int'(level), exp_lvl);
        check(int'(n_active) == exp_act, "R2 active workers", int'(n_active), exp_act);
        check(int'(dom_en) == exp_dom, "R3 domain enables", int'(dom_en), exp_dom);
        check(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
        if (cnt > 0) begin
            while (!disp_valid) begin
                @(negedge clk);
                cyc++;
            end
            check(cyc == gap + 1, "R4 settle gap", cyc, gap + 1);
            while (busy) @(negedge clk);
        end else begin
            while (busy) begin
                @(negedge clk);
                cyc++;
            end
            check(cyc == gap + 1, "R6 empty frame length", cyc, gap + 1);
        end
        check(sbq.size() == 0, "R6 all tiles issued", sbq.size(), 0);
    endtask

    task automatic cg_write(input int id, input bit addr, input int data, input int clr);
        @(negedge clk);
        cg_wr_en   = 1'b1;
        cg_wr_addr = addr;
        cg_wr_id   = IW'(id);
        cg_wr_data = WW'(data);
        wait_clear = WW'(clr);
        @(negedge clk);
        cg_wr_en   = 1'b0;
        cg_wr_data = '0;
        wait_clear = '0;
    endtask

    task automatic clear_pulse(input int clr);
        @(negedge clk);
        wait_clear = WW'(clr);
        @(negedge clk);
        wait_clear = '0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        frame_start = 1'b0;
        tile_count = '0;
        settle_cycles = '0;
        cg_wr_en = 1'b0;
        cg_wr_addr = 1'b0;
        cg_wr_id = '0;
        cg_wr_data = '0;
        wait_clear = '0;
        set_thr(10, 20, 30);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 1'b0, "R11 busy", int'(busy), 0);
        check(disp_valid == 1'b0, "R11 disp_valid", int'(disp_valid), 0);
        check(level == '0, "R11 level", int'(level), 0);
        check(dom_en == '0, "R11 dom_en", int'(dom_en), 0);
        check(clk_en == '0, "R11 clk_en", int'(clk_en), 0);
        rst_n = 1'b1;

        // R1 classification across levels and at threshold boundaries
        run_frame(5, 3, 0);
        run_frame(9, 1, 0);
        run_frame(10, 2, 1);
        run_frame(25, 4, 2);

        // R5: a request in mid-frame is ignored
        fork
            run_frame(40, 3, 3);
            begin
                do @(negedge clk); while (!disp_valid);
                tile_count  = CW'(3);
                frame_start = 1'b1;
                @(negedge clk);
                frame_start = 1'b0;
                check(int'(level) == 3, "R5 level unchanged", int'(level), 3);
            end
        join
        @(negedge clk);
        check(busy == 1'b0, "R5 ignored request did not start a frame", int'(busy), 0);
        check(clk_en[15] == 1'b1, "R10 all domains on", int'(clk_en[15]), 1);

        // R2: lower thresholds give more workers for the same count
        set_thr(2, 4, 6);
        run_frame(5, 2, 2);
        check(int'(n_active) > 4, "R2 lower thresholds more workers", int'(n_active), 12);
        check(clk_en[13] == 1'b0, "R10 worker in off domain", int'(clk_en[13]), 0);
        check(clk_en[9] == 1'b1, "R10 worker in on domain", int'(clk_en[9]), 1);

        // R6: zero-tile frame with zero settle
        set_thr(10, 20, 30);
        run_frame(0, 0, 0);

        // R9: end write collides with a tile issued to the same worker
        fork
            run_frame(16, 1, 1);
            begin
                do @(negedge clk); while (!(disp_valid && disp_worker == IW'(3)));
                cg_wr_en   = 1'b1;
                cg_wr_addr = 1'b0;
                cg_wr_id   = IW'(3);
                @(negedge clk);
                cg_wr_en = 1'b0;
                check(clk_en[3] == 1'b1, "R9 tile wins over end write", int'(clk_en[3]), 1);
            end
        join

        // R7 end write gates until next tile
        check(clk_en[6] == 1'b1, "R7 before end write", int'(clk_en[6]), 1);
        cg_write(6, 1'b0, 0, 0);
        check(clk_en[6] == 1'b0, "R7 gated after end write", int'(clk_en[6]), 0);
        repeat (3) @(negedge clk);
        check(clk_en[6] == 1'b0, "R7 stays gated", int'(clk_en[6]), 0);
        run_frame(16, 1, 1);
        check(clk_en[6] == 1'b1, "R7 restored by tile", int'(clk_en[6]), 1);

        // R8 wait conditions
        cg_write(2, 1'b1, 5, 0);
        check(clk_en[2] == 1'b0, "R8 gated on wait", int'(clk_en[2]), 0);
        clear_pulse(1);
        check(clk_en[2] == 1'b0, "R8 one condition left", int'(clk_en[2]), 0);
        clear_pulse(4);
        check(clk_en[2] == 1'b1, "R8 restored when all clear", int'(clk_en[2]), 1);
        cg_write(2, 1'b1, 2, 2);
        check(clk_en[2] == 1'b1, "R8 same-cycle clear", int'(clk_en[2]), 1);
        cg_write(2, 1'b1, 3, 1);
        check(clk_en[2] == 1'b0, "R8 partial same-cycle clear", int'(clk_en[2]), 0);
        clear_pulse(2);
        check(clk_en[2] == 1'b1, "R8 restored after partial", int'(clk_en[2]), 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule